// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block connects a synchronous request port inside a chip to an external asynchronous static RAM of up to 256K words by 16 bits. A requester presents one single-word read or write at a time on a valid/ready handshake. Each request carries an 18-bit word address, 16 bits of write data and a two-bit byte-lane mask. The controller then steps the memory's active-low strobes through a timed sequence. Every access, write or read, ends in a one-cycle response pulse. A read also returns the data on that pulse.

The length of each phase is a whole number of clock cycles. It is derived from nanosecond parameters and the clock period, rounded up, with a minimum of one cycle. There are three such phases: the read access time, the write strobe pulse and the bus turnaround before the controller drives data. The shared data pins appear as a separate input bus, output bus and drive enable. The pad ring joins them.

Top module: `sram_port_ctrl`

## Requirements
- R1: After reset, and while reset is held, the chip enable, write enable, output enable and both byte enables are high. The data drive enable is low, `req_ready` is high and `rsp_valid` is low.
- R2: A request is accepted only on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only in idle, and it stays low from the accepting edge through the response cycle.
- R3: A read with a nonzero mask holds chip enable and output enable low and write enable high for RD_CYC = ceil(ACC_NS/CLK_NS) cycles. The address pins carry the request address throughout. `rsp_valid` rises RD_CYC+1 cycles after the accepting edge.
- R4: Mask bit 0 selects data bits 7:0 through the lower byte enable, and mask bit 1 selects bits 15:8 through the upper byte enable. Each byte enable is low for the whole access when its mask bit is 1. On a read, a lane whose mask bit is 0 returns zero in `rsp_rdata`.
- R5: The data sampled from the memory on the last read cycle appears on `rsp_rdata` during the response pulse and matches the last write to that address on the enabled lanes.
- R6: A write with a nonzero mask keeps output enable high for the whole access. Write enable goes low TA_CYC = ceil(TURN_NS/CLK_NS) cycles after the accepting edge.
- R7: Write enable stays low for exactly WP_CYC = ceil(WPULSE_NS/CLK_NS) cycles, with chip enable low, and the controller drives the data pins in exactly those cycles. The drive enable falls on the same edge where write enable rises. `rsp_valid` rises TA_CYC+WP_CYC+1 cycles after the accepting edge.
- R8: The controller never drives the data pins while output enable is low, and output enable is never low while write enable is low.
- R9: Chip enable is low from the cycle after acceptance through the response cycle, and high in the cycle after the response.
- R10: A request whose mask is 0 leaves every memory strobe high. It produces `rsp_valid` one cycle after the accepting edge.
- R11: `rsp_valid` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_lb_n | output | 1 | Lower byte enable, active low |
| sram_ub_n | output | 1 | Upper byte enable, active low |
| sram_addr | output | 18 | Memory address bus |
| sram_dq_out | output | 16 | Data to drive onto the memory bus |
| sram_dq_oe | output | 1 | Drive enable for sram_dq_out |
| sram_dq_in | input | 16 | Data read from the memory bus |

## Verification
The hardest thing to observe from the ports is the ownership of the data pins at the boundary between phases. Driving while output enable is still low, or releasing the bus one edge late after write enable rises, only shows as a one-cycle overlap of strobes. The bench places a behavioural memory on the pins that drives the bus only in its read condition. At every cycle it counts any cycle where both sides drive. It also checks that the drive enable and a low write enable coincide cycle for cycle. Reads immediately follow partial-lane writes to the same address, so a lane written late or masked wrongly appears as a data mismatch.

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl #(
  parameter int AW         = 18,
  parameter int DW         = 16,
  parameter int CLK_NS     = 20,
  parameter int ACC_NS     = 10,
  parameter int WPULSE_NS  = 7,
  parameter int TURN_NS    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_be,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          sram_ce_n,
  output logic          sram_we_n,
  output logic          sram_oe_n,
  output logic          sram_lb_n,
  output logic          sram_ub_n,
  output logic [AW-1:0] sram_addr,
  output logic [DW-1:0] sram_dq_out,
  output logic          sram_dq_oe,
  input  logic [DW-1:0] sram_dq_in
);
  localparam int LANE = DW / 2;

  function automatic int to_cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int RD_CYC = to_cyc(ACC_NS);
  localparam int WP_CYC = to_cyc(WPULSE_NS);
  localparam int TA_CYC = to_cyc(TURN_NS);
  localparam int MAXC   = (RD_CYC > WP_CYC) ? ((RD_CYC > TA_CYC) ? RD_CYC : TA_CYC)
                                            : ((WP_CYC > TA_CYC) ? WP_CYC : TA_CYC);
  localparam int CW     = (MAXC < 2) ? 1 : $clog2(MAXC);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_TURN, S_WR, S_DONE} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic [1:0]    lane_off;
  logic [DW-1:0] lane_mask;
  logic [DW-1:0] rdata_q;

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_lane
      assign lane_mask[g*LANE +: LANE] = {LANE{~lane_off[g]}};
    end
  endgenerate

  assign req_ready = (state == S_IDLE);
  assign rsp_valid = (state == S_DONE);
  assign rsp_rdata = rdata_q;
  assign sram_lb_n = lane_off[0];
  assign sram_ub_n = lane_off[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cnt         <= '0;
      sram_ce_n   <= 1'b1;
      sram_we_n   <= 1'b1;
      sram_oe_n   <= 1'b1;
      lane_off    <= 2'b11;
      sram_dq_oe  <= 1'b0;
      sram_addr   <= '0;
      sram_dq_out <= '0;
      rdata_q     <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          sram_addr   <= req_addr;
          sram_dq_out <= req_wdata;
          if (req_be == 2'b00) begin
            state <= S_DONE;
          end else begin
            sram_ce_n <= 1'b0;
            lane_off  <= ~req_be;
            if (req_write) begin
              state <= S_TURN;
              cnt   <= CW'(TA_CYC - 1);
            end else begin
              state     <= S_RD;
              sram_oe_n <= 1'b0;
              cnt       <= CW'(RD_CYC - 1);
            end
          end
        end
        S_RD: if (cnt == '0) begin
          rdata_q   <= sram_dq_in & lane_mask;
          sram_oe_n <= 1'b1;
          state     <= S_DONE;
        end else cnt <= cnt - 1'b1;
        S_TURN: if (cnt == '0) begin
          sram_we_n  <= 1'b0;
          sram_dq_oe <= 1'b1;
          cnt        <= CW'(WP_CYC - 1);
          state      <= S_WR;
        end else cnt <= cnt - 1'b1;
        S_WR: if (cnt == '0) begin
          sram_we_n  <= 1'b1;
          sram_dq_oe <= 1'b0;
          state      <= S_DONE;
        end else cnt <= cnt - 1'b1;
        default: begin
          sram_ce_n <= 1'b1;
          lane_off  <= 2'b11;
          state     <= S_IDLE;
        end
      endcase
    end
  end

  // R8
  drive_vs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> sram_oe_n);
  // R8
  oe_vs_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> sram_we_n);
  // R7
  we_in_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> !sram_ce_n);
  // R7
  release_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> !sram_dq_oe);
  // R11
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R9
  ce_high_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> sram_ce_n);
endmodule

// File: tb/sram_port_ctrl_bench.sv
module sram_port_ctrl_bench;
  localparam int AW = 18, DW = 16;
  localparam int RD = 3, WP = 2, TA = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0] req_be = 2'b00;
  logic req_ready, rsp_valid, ce_n, we_n, oe_n, lb_n, ub_n, dq_oe;
  logic [DW-1:0] rsp_rdata, dq_out, dq_in;
  logic [AW-1:0] m_addr;

  always #10 clk = ~clk;

  sram_port_ctrl #(.AW(AW), .DW(DW), .CLK_NS(20), .ACC_NS(50), .WPULSE_NS(30), .TURN_NS(20))
  u_sram_port_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_ce_n(ce_n), .sram_we_n(we_n),
    .sram_oe_n(oe_n), .sram_lb_n(lb_n), .sram_ub_n(ub_n), .sram_addr(m_addr),
    .sram_dq_out(dq_out), .sram_dq_oe(dq_oe), .sram_dq_in(dq_in));

  logic [DW-1:0] mem [256];
  logic mem_drv;
  assign mem_drv = !ce_n && !oe_n && we_n && !(lb_n && ub_n);
  assign dq_in = mem_drv ? {ub_n ? 8'hEE : mem[m_addr[7:0]][15:8],
                            lb_n ? 8'hEE : mem[m_addr[7:0]][7:0]} : 16'hEEEE;
  always @(posedge we_n) if (!ce_n) begin
    if (!lb_n) mem[m_addr[7:0]][7:0]  <= dq_out[7:0];
    if (!ub_n) mem[m_addr[7:0]][15:8] <= dq_out[15:8];
  end

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct {
    int lat, we_lo, oe_lo, ce_hi, rdy_hi, clash, drv_mis, addr_bad;
    logic [1:0] lanes;
    logic [DW-1:0] q;
    logic ce_after;
  } stats_t;

  task automatic access(input bit w, input logic [1:0] be, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, output stats_t s);
    s = '{default: 0};
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_be = be; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    s.lat = 1;
    s.lanes = {~ub_n, ~lb_n};
    forever begin
      s.we_lo   += int'(!we_n);
      s.oe_lo   += int'(!oe_n);
      s.ce_hi   += int'(ce_n);
      s.rdy_hi  += int'(req_ready);
      s.clash   += int'(dq_oe && mem_drv);
      s.drv_mis += int'(dq_oe != !we_n);
      s.addr_bad += int'(be != 2'b00 && m_addr != a);
      if (rsp_valid || s.lat > 40) break;
      @(negedge clk);
      s.lat++;
    end
    s.q = rsp_rdata;
    @(negedge clk);
    s.ce_after = ce_n;
    chk(!rsp_valid, "R11 pulse width", rsp_valid, 0);
  endtask

  // {write, be[1:0], addr[7:0], data[15:0], expect[15:0]}
  localparam logic [42:0] VEC [11] = '{
    {1'b1, 2'b11, 8'h10, 16'h1234, 16'h0000},
    {1'b0, 2'b11, 8'h10, 16'h0000, 16'h1234},
    {1'b1, 2'b01, 8'h10, 16'hABCD, 16'h0000},
    {1'b0, 2'b11, 8'h10, 16'h0000, 16'h12CD},
    {1'b1, 2'b10, 8'h10, 16'h5F77, 16'h0000},
    {1'b0, 2'b11, 8'h10, 16'h0000, 16'h5FCD},
    {1'b0, 2'b01, 8'h10, 16'h0000, 16'h00CD},
    {1'b0, 2'b10, 8'h10, 16'h0000, 16'h5F00},
    {1'b1, 2'b11, 8'hFF, 16'hF00F, 16'h0000},
    {1'b0, 2'b11, 8'hFF, 16'h0000, 16'hF00F},
    {1'b0, 2'b11, 8'h10, 16'h0000, 16'h5FCD}
  };

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    stats_t s;
    repeat (3) @(negedge clk);
    // R1 state held in reset
    chk({ce_n, we_n, oe_n, lb_n, ub_n, dq_oe, req_ready, rsp_valid} == 8'b11111010,
        "R1 in reset", {ce_n, we_n, oe_n, lb_n, ub_n, dq_oe, req_ready, rsp_valid}, 8'hFA);
    rst_n = 1'b1;
    @(negedge clk);
    chk({ce_n, we_n, oe_n, lb_n, ub_n, dq_oe, req_ready, rsp_valid} == 8'b11111010,
        "R1 after reset", {ce_n, we_n, oe_n, lb_n, ub_n, dq_oe, req_ready, rsp_valid}, 8'hFA);

    for (int i = 0; i < 11; i++) begin
      logic w; logic [1:0] be; logic [AW-1:0] a; logic [DW-1:0] d, e;
      w = VEC[i][42]; be = VEC[i][41:40];
      a = {10'h2A5, VEC[i][39:32]}; d = VEC[i][31:16]; e = VEC[i][15:0];
      access(w, be, a, d, s);
      chk(s.rdy_hi == 0, "R2 ready low while busy", s.rdy_hi, 0);
      chk(s.lanes == be, "R4 byte enables follow mask", s.lanes, be);
      chk(s.ce_hi == 0, "R9 ce low during access", s.ce_hi, 0);
      chk(s.ce_after == 1'b1, "R9 ce high after response", s.ce_after, 1);
      chk(s.clash == 0, "R8 no bus contention", s.clash, 0);
      chk(s.addr_bad == 0, "R3 address held", s.addr_bad, 0);
      if (w) begin
        chk(s.lat == TA + WP + 1, "R7 write latency", s.lat, TA + WP + 1);
        chk(s.we_lo == WP, "R7 write pulse length", s.we_lo, WP);
        chk(s.oe_lo == 0, "R6 oe high during write", s.oe_lo, 0);
        chk(s.drv_mis == 0, "R7 drive matches write strobe", s.drv_mis, 0);
      end else begin
        chk(s.lat == RD + 1, "R3 read latency", s.lat, RD + 1);
        chk(s.oe_lo == RD, "R3 oe low cycles", s.oe_lo, RD);
        chk(s.we_lo == 0, "R3 we high during read", s.we_lo, 0);
        chk(s.q == e, "R5 R4 read data", s.q, e);
      end
    end

    // R6: turnaround, write enable must not fall before TA cycles
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_be = 2'b11; req_addr = 18'h00042; req_wdata = 16'h0F0F;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(we_n == 1'b1 && dq_oe == 1'b0, "R6 no drive in turnaround cycle", {we_n, dq_oe}, 2'b10);
    @(negedge clk);
    chk(we_n == 1'b0 && dq_oe == 1'b1, "R6 strobe after turnaround", {we_n, dq_oe}, 2'b01);
    while (!rsp_valid) @(negedge clk);
    @(negedge clk);

    // R10: empty mask does nothing on the memory pins
    access(1'b1, 2'b00, 18'h00010, 16'hDEAD, s);
    chk(s.lat == 1, "R10 empty mask latency", s.lat, 1);
    chk(s.we_lo == 0 && s.oe_lo == 0, "R10 no strobes", s.we_lo + s.oe_lo, 0);
    access(1'b0, 2'b00, 18'h00010, 16'h0000, s);
    chk(s.lat == 1 && s.oe_lo == 0, "R10 empty read", s.oe_lo, 0);
    access(1'b0, 2'b11, 18'h00010, 16'h0000, s);
    chk(s.q == 16'h5FCD, "R10 memory untouched by empty write", s.q, 16'h5FCD);
    access(1'b0, 2'b11, 18'h00042, 16'h0000, s);
    chk(s.q == 16'h0F0F, "R5 turnaround write stored", s.q, 16'h0F0F);

    // R1: reset in mid-access returns pins to idle
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_be = 2'b11;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk({ce_n, we_n, oe_n, dq_oe, req_ready} == 5'b11101, "R1 reset mid-write",
        {ce_n, we_n, oe_n, dq_oe, req_ready}, 5'b11101);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule